// File: doc/BRIEF.md
# Alternate Instruction Mode Front-End Decoder

This block sits at the front of an instruction pipeline and watches a byte stream. In normal mode it passes every byte through unchanged, with its start-of-instruction marker. It looks out for one two-byte escape opcode. When an enable bit in a small feature control register is set, that opcode becomes a near branch to the address held in EAX. The branch also switches the decoder into a hidden alternate mode. When the enable bit is clear, the same opcode raises an invalid-opcode exception.

In alternate mode the stream carries 32-bit instruction words. Each word is wrapped in a fixed load-effective-address encoding: the three bytes 0x8D, 0x84, 0x00, preceded by the byte 0x67 when the code segment is 16-bit. The decoder strips this wrapper, assembles the four displacement bytes, and issues the result as one alternate instruction word. One opcode value in the top byte of the word marks a return instruction, which takes the decoder back to normal decoding. A byte that breaks the wrapper pattern raises the exception and also forces a return to normal decoding.

Only the most privileged level can change the control register. Each write carries a bit mask, so software can update the enable bit without disturbing the neighbouring bits.

Top module: `alt_mode_front`

## Requirements
- R1: After reset the control register reads 0 and the decoder is in normal mode. A write at privilege level 0 changes exactly the bits set in `ctlWrMask` to the matching bits of `ctlWrData`. The new value is visible on `ctlValue` one cycle after the write.
- R2: A control write at privilege level 1, 2 or 3 leaves `ctlValue` unchanged.
- R3: With control bit 0 set, the byte 0x0F marked as start, followed by the byte 0x3F not marked as start, is accepted at any privilege level. One cycle after the 0x3F byte, `branchValid` pulses with `branchTarget` equal to the `eaxIn` value sampled alongside 0x3F, and `altMode` is 1.
- R4: With control bit 0 clear, the same two-byte sequence pulses `invalidOp`. There is no branch, `altMode` stays 0, and neither byte appears on the pass-through output.
- R5: The two-byte sequence is recognized only when its first byte is marked as start and its second byte is not. In any other arrangement, both bytes pass through in order.
- R6: In normal mode, every byte outside a recognized sequence is delivered on `passData`/`passStart` in arrival order, with its value and start marker unchanged.
- R7: In alternate mode with a 32-bit code segment (`cs16` = 0), the bytes 0x8D 0x84 0x00 followed by four bytes produce one `altWordValid` pulse. `altWord` holds the first displacement byte in bits 7:0 and the last one in bits 31:24.
- R8: With `cs16` = 1, the byte 0x67 must come before the 0x8D 0x84 0x00 wrapper. The word is then assembled exactly as in R7.
- R9: A word whose bits 31:24 equal `RET_OPC` (default 0xA5) is still issued, with `altReturn` = 1, and `altMode` reads 0 in the same cycle. Any other word is issued with `altReturn` = 0 and the decoder stays in alternate mode.
- R10: In alternate mode, any byte that differs from the expected wrapper or prefix byte pulses `invalidOp` and returns the decoder to normal mode. Bytes that follow then pass through as in R6.
- R11: Each of `branchValid`, `invalidOp` and `altWordValid` is a single-cycle pulse, raised one cycle after the byte that causes it. At most one of these pulses and `passValid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Stream byte present this cycle |
| byteData | input | 8 | Stream byte |
| byteStart | input | 1 | Byte is the first byte of an instruction |
| privLevel | input | PRIV_W | Current privilege level, 0 most privileged |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | CTL_W | Control write data |
| ctlWrMask | input | CTL_W | Bits to be written |
| cs16 | input | 1 | Code segment is 16-bit |
| eaxIn | input | WORD_W | Current EAX value, used as branch target |
| ctlValue | output | CTL_W | Control register contents |
| altMode | output | 1 | Decoder is in alternate mode |
| branchValid | output | 1 | Branch request pulse |
| branchTarget | output | WORD_W | Branch target address |
| invalidOp | output | 1 | Invalid-opcode exception pulse |
| altWordValid | output | 1 | Alternate instruction word strobe |
| altWord | output | WORD_W | Unwrapped alternate instruction |
| altReturn | output | 1 | Issued word is the return instruction |
| passValid | output | 1 | Pass-through byte strobe |
| passData | output | 8 | Pass-through byte |
| passStart | output | 1 | Start marker of pass-through byte |

## Verification
The assertions assume that `privLevel`, `ctlWrEn`, `ctlWrData`, `ctlWrMask`, `cs16` and `eaxIn` are driven to known values in every cycle after reset. They also assume that `cs16` stays constant from the branch until the word is complete. Their past-value checks rely on inputs that change only between clock edges. The bench drives every input on the falling edge and holds `cs16` for a whole alternate-mode session. It also always follows a held 0x0F with another byte, so the pass-through stream can be compared in order once the bench goes idle.

// File: rtl/altmode_pkg.sv
package altmode_pkg;

  localparam logic [7:0] ESC_BYTE   = 8'h0F;
  localparam logic [7:0] ENTRY_BYTE = 8'h3F;
  localparam logic [7:0] PFX16_BYTE = 8'h67;
  localparam logic [7:0] WRAP0_BYTE = 8'h8D;
  localparam logic [7:0] WRAP1_BYTE = 8'h84;
  localparam logic [7:0] WRAP2_BYTE = 8'h00;

  typedef enum logic [2:0] {
    ST_X86,
    ST_WAIT,
    ST_W8D,
    ST_W84,
    ST_W00,
    ST_DISP
  } dec_state_e;

  typedef struct packed {
    logic holdLoad;
    logic holdClr;
    logic emitHold;
    logic emitByte;
    logic dispShift;
    logic issueWord;
    logic isReturn;
    logic branch;
    logic fault;
  } dp_strobe_t;

endpackage

// File: rtl/alt_ctl.sv
module alt_ctl
  import altmode_pkg::*;
#(
  parameter int              CTL_W      = 8,
  parameter int              EN_BIT     = 0,
  parameter logic [CTL_W-1:0] CTL_RESET = '0,
  parameter int              PRIV_W     = 2,
  parameter int              WORD_BYTES = 4,
  parameter logic [7:0]      RET_OPC    = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              byteStart,
  input  logic [PRIV_W-1:0] privLevel,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  input  logic [CTL_W-1:0]  ctlWrMask,
  input  logic              cs16,
  input  logic              holdValid,
  input  logic              holdEsc,
  output logic [CTL_W-1:0]  ctlValue,
  output logic              altMode,
  output dp_strobe_t        stb
);

  localparam int IDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

  dec_state_e       state, stateNext;
  logic [IDX_W-1:0] dispIdx, dispIdxNext;
  logic [CTL_W-1:0] ctlReg;
  logic             ctlWrOk;
  logic             enabled;
  logic [7:0]       wrapExpect;

  // Control register: masked update, privileged level only
  assign ctlWrOk = ctlWrEn && (privLevel == '0);
  assign enabled = ctlReg[EN_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= CTL_RESET;
    end else if (ctlWrOk) begin
      ctlReg <= (ctlReg & ~ctlWrMask) | (ctlWrData & ctlWrMask);
    end
  end

  // Expected byte for the fixed wrapper states
  always_comb begin
    unique case (state)
      ST_W8D:  wrapExpect = WRAP0_BYTE;
      ST_W84:  wrapExpect = WRAP1_BYTE;
      default: wrapExpect = WRAP2_BYTE;
    endcase
  end

  always_comb begin
    stb         = '0;
    stateNext   = state;
    dispIdxNext = dispIdx;
    unique case (state)
      ST_X86: begin
        if (byteValid) begin
          if (holdValid && holdEsc && !byteStart && byteData == ENTRY_BYTE) begin
            stb.holdClr = 1'b1;
            if (enabled) begin
              stb.branch = 1'b1;
              stateNext  = ST_WAIT;
            end else begin
              stb.fault = 1'b1;
            end
          end else if (holdValid) begin
            stb.emitHold = 1'b1;
            stb.holdLoad = 1'b1;
          end else if (byteStart && byteData == ESC_BYTE) begin
            stb.holdLoad = 1'b1;
          end else begin
            stb.emitByte = 1'b1;
          end
        end else if (holdValid && !holdEsc) begin
          stb.emitHold = 1'b1;
          stb.holdClr  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (byteValid) begin
          if (cs16 && byteData == PFX16_BYTE) begin
            stateNext = ST_W8D;
          end else if (!cs16 && byteData == WRAP0_BYTE) begin
            stateNext = ST_W84;
          end else begin
            stb.fault = 1'b1;
            stateNext = ST_X86;
          end
        end
      end
      ST_W8D, ST_W84, ST_W00: begin
        if (byteValid) begin
          if (byteData != wrapExpect) begin
            stb.fault = 1'b1;
            stateNext = ST_X86;
          end else if (state == ST_W8D) begin
            stateNext = ST_W84;
          end else if (state == ST_W84) begin
            stateNext = ST_W00;
          end else begin
            stateNext   = ST_DISP;
            dispIdxNext = '0;
          end
        end
      end
      ST_DISP: begin
        if (byteValid) begin
          if (dispIdx == LAST_IDX) begin
            stb.issueWord = 1'b1;
            stb.isReturn  = (byteData == RET_OPC);
            stateNext     = (byteData == RET_OPC) ? ST_X86 : ST_WAIT;
          end else begin
            stb.dispShift = 1'b1;
            dispIdxNext   = dispIdx + 1'b1;
          end
        end
      end
      default: stateNext = ST_X86;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_X86;
      dispIdx <= '0;
    end else begin
      state   <= stateNext;
      dispIdx <= dispIdxNext;
    end
  end

  assign ctlValue = ctlReg;
  assign altMode  = (state != ST_X86);

endmodule

// File: rtl/alt_dp.sv
module alt_dp
  import altmode_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        byteData,
  input  logic              byteStart,
  input  logic [WORD_W-1:0] eaxIn,
  input  dp_strobe_t        stb,
  output logic              holdValid,
  output logic              holdEsc,
  output logic              branchValid,
  output logic [WORD_W-1:0] branchTarget,
  output logic              invalidOp,
  output logic              altWordValid,
  output logic [WORD_W-1:0] altWord,
  output logic              altReturn,
  output logic              passValid,
  output logic [7:0]        passData,
  output logic              passStart
);

  localparam int SH_W = WORD_W - 8;

  logic [7:0]      holdData;
  logic            holdStart;
  logic [SH_W-1:0] dispReg;
  logic [SH_W-1:0] dispNext;

  // Little-endian assembly: earlier bytes move toward bit 0
  generate
    if (SH_W > 8) begin : g_wide
      assign dispNext = {byteData, dispReg[SH_W-1:8]};
    end else begin : g_narrow
      assign dispNext = byteData;
    end
  endgenerate

  assign holdEsc = holdStart && (holdData == ESC_BYTE);

  // One-byte holding slot for a possible escape opcode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdData  <= '0;
      holdStart <= 1'b0;
    end else if (stb.holdLoad) begin
      holdValid <= 1'b1;
      holdData  <= byteData;
      holdStart <= byteStart;
    end else if (stb.holdClr) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispReg <= '0;
    end else if (stb.dispShift) begin
      dispReg <= dispNext;
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      branchValid  <= 1'b0;
      branchTarget <= '0;
      invalidOp    <= 1'b0;
      altWordValid <= 1'b0;
      altWord      <= '0;
      altReturn    <= 1'b0;
      passValid    <= 1'b0;
      passData     <= '0;
      passStart    <= 1'b0;
    end else begin
      branchValid  <= stb.branch;
      invalidOp    <= stb.fault;
      altWordValid <= stb.issueWord;
      passValid    <= stb.emitHold || stb.emitByte;
      if (stb.branch) begin
        branchTarget <= eaxIn;
      end
      if (stb.issueWord) begin
        altWord   <= {byteData, dispReg};
        altReturn <= stb.isReturn;
      end
      if (stb.emitHold) begin
        passData  <= holdData;
        passStart <= holdStart;
      end else if (stb.emitByte) begin
        passData  <= byteData;
        passStart <= byteStart;
      end
    end
  end

endmodule

// File: rtl/alt_mode_front.sv
module alt_mode_front
  import altmode_pkg::*;
#(
  parameter int               CTL_W     = 8,
  parameter int               EN_BIT    = 0,
  parameter logic [CTL_W-1:0] CTL_RESET = '0,
  parameter int               PRIV_W    = 2,
  parameter int               WORD_W    = 32,
  parameter logic [7:0]       RET_OPC   = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              byteStart,
  input  logic [PRIV_W-1:0] privLevel,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  input  logic [CTL_W-1:0]  ctlWrMask,
  input  logic              cs16,
  input  logic [WORD_W-1:0] eaxIn,
  output logic [CTL_W-1:0]  ctlValue,
  output logic              altMode,
  output logic              branchValid,
  output logic [WORD_W-1:0] branchTarget,
  output logic              invalidOp,
  output logic              altWordValid,
  output logic [WORD_W-1:0] altWord,
  output logic              altReturn,
  output logic              passValid,
  output logic [7:0]        passData,
  output logic              passStart
);

  localparam int WORD_BYTES = WORD_W / 8;

  dp_strobe_t stb;
  logic       holdValid;
  logic       holdEsc;

  alt_ctl #(
    .CTL_W     (CTL_W),
    .EN_BIT    (EN_BIT),
    .CTL_RESET (CTL_RESET),
    .PRIV_W    (PRIV_W),
    .WORD_BYTES(WORD_BYTES),
    .RET_OPC   (RET_OPC)
  ) i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .byteData (byteData),
    .byteStart(byteStart),
    .privLevel(privLevel),
    .ctlWrEn  (ctlWrEn),
    .ctlWrData(ctlWrData),
    .ctlWrMask(ctlWrMask),
    .cs16     (cs16),
    .holdValid(holdValid),
    .holdEsc  (holdEsc),
    .ctlValue (ctlValue),
    .altMode  (altMode),
    .stb      (stb)
  );

  alt_dp #(
    .WORD_W(WORD_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .byteData    (byteData),
    .byteStart   (byteStart),
    .eaxIn       (eaxIn),
    .stb         (stb),
    .holdValid   (holdValid),
    .holdEsc     (holdEsc),
    .branchValid (branchValid),
    .branchTarget(branchTarget),
    .invalidOp   (invalidOp),
    .altWordValid(altWordValid),
    .altWord     (altWord),
    .altReturn   (altReturn),
    .passValid   (passValid),
    .passData    (passData),
    .passStart   (passStart)
  );

endmodule

// File: rtl/alt_mode_chk.sv
module alt_mode_chk #(
  parameter int CTL_W  = 8,
  parameter int EN_BIT = 0,
  parameter int PRIV_W = 2,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [PRIV_W-1:0] privLevel,
  input logic              ctlWrEn,
  input logic [CTL_W-1:0]  ctlWrMask,
  input logic [WORD_W-1:0] eaxIn,
  input logic [CTL_W-1:0]  ctlValue,
  input logic              altMode,
  input logic              branchValid,
  input logic [WORD_W-1:0] branchTarget,
  input logic              invalidOp,
  input logic              altWordValid,
  input logic              altReturn,
  input logic              passValid
);

  // R1
  ctl_unmasked_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && privLevel == '0) |=> (((ctlValue ^ $past(ctlValue)) & ~$past(ctlWrMask)) == '0));

  // R2
  ctl_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctlWrEn && privLevel == '0) |=> $stable(ctlValue));

  // R3
  branch_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchValid |-> (altMode && !$past(altMode) && branchTarget == $past(eaxIn)));

  // R4
  branch_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchValid |-> $past(ctlValue[EN_BIT]));

  // R10
  fault_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidOp |-> !altMode);

  // R6
  pass_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    passValid |-> !$past(altMode));

  // R7
  word_in_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    altWordValid |-> $past(altMode));

  // R9
  return_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    altWordValid |-> (altMode == !altReturn));

  // R11
  branch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchValid |=> !branchValid);

  // R11
  single_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({passValid, branchValid, invalidOp, altWordValid}));

endmodule

bind alt_mode_front alt_mode_chk #(
  .CTL_W (CTL_W),
  .EN_BIT(EN_BIT),
  .PRIV_W(PRIV_W),
  .WORD_W(WORD_W)
) i_alt_mode_chk (.*);

// File: tb/test_alt_mode_front.sv
module test_alt_mode_front;
  localparam int CLK_PERIOD = 10;
  localparam int CTL_W = 8;
  localparam int PRIV_W = 2;
  localparam int WORD_W = 32;
  localparam logic [7:0] RET_OPC = 8'hA5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              byteValid = 1'b0;
  logic [7:0]        byteData = '0;
  logic              byteStart = 1'b0;
  logic [PRIV_W-1:0] privLevel = '0;
  logic              ctlWrEn = 1'b0;
  logic [CTL_W-1:0]  ctlWrData = '0;
  logic [CTL_W-1:0]  ctlWrMask = '0;
  logic              cs16 = 1'b0;
  logic [WORD_W-1:0] eaxIn = '0;
  logic [CTL_W-1:0]  ctlValue;
  logic              altMode;
  logic              branchValid;
  logic [WORD_W-1:0] branchTarget;
  logic              invalidOp;
  logic              altWordValid;
  logic [WORD_W-1:0] altWord;
  logic              altReturn;
  logic              passValid;
  logic [7:0]        passData;
  logic              passStart;

  int checks = 0;
  int errors = 0;
  logic [8:0] passLog [0:511];
  int passCnt = 0;
  logic [CTL_W-1:0] expCtl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alt_mode_front #(
    .CTL_W(CTL_W), .EN_BIT(0), .CTL_RESET('0), .PRIV_W(PRIV_W),
    .WORD_W(WORD_W), .RET_OPC(RET_OPC)
  ) i_alt_mode_front (.*);

  // Pass-through log, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && passValid) begin
      if (passCnt < 512) passLog[passCnt] = {passStart, passData};
      passCnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic putByte(input logic [7:0] d, input logic s);
    byteValid = 1'b1;
    byteData  = d;
    byteStart = s;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    byteValid = 1'b0;
    byteStart = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic ctlWrite(input logic [PRIV_W-1:0] p, input logic [CTL_W-1:0] d,
                          input logic [CTL_W-1:0] m);
    privLevel = p;
    ctlWrEn   = 1'b1;
    ctlWrData = d;
    ctlWrMask = m;
    @(negedge clk);
    ctlWrEn   = 1'b0;
  endtask

  task automatic enterAlt(input logic [31:0] eax);
    eaxIn = eax;
    putByte(8'h0F, 1'b1);
    putByte(8'h3F, 1'b0);
    check("R11 branch pulse", 32'(branchValid), 32'd1);
    check("R3 branch target", branchTarget, eax);
    check("R3 alternate mode on", 32'(altMode), 32'd1);
  endtask

  task automatic sendWord(input logic [31:0] w, input logic c16);
    logic ret;
    ret = (w[31:24] == RET_OPC);
    if (c16) putByte(8'h67, 1'b0);
    putByte(8'h8D, 1'b0);
    check("R11 branch single cycle", 32'(branchValid), 32'd0);
    putByte(8'h84, 1'b0);
    putByte(8'h00, 1'b0);
    for (int k = 0; k < 4; k++) putByte(w[8*k +: 8], 1'b0);
    check("R11 word strobe", 32'(altWordValid), 32'd1);
    check(c16 ? "R8 word value" : "R7 word value", altWord, w);
    check("R9 return flag", 32'(altReturn), 32'(ret));
    check("R9 mode after word", 32'(altMode), 32'(!ret));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] good [0:2];
    good[0] = 8'h8D; good[1] = 8'h84; good[2] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset ctl", 32'(ctlValue), 32'd0);
    check("R1 reset mode", 32'(altMode), 32'd0);
    check("R11 reset pulses", {28'd0, branchValid, invalidOp, altWordValid, passValid}, 32'd0);

    // R2 unprivileged writes
    for (int p = 1; p < 4; p++) begin
      ctlWrite(PRIV_W'(p), 8'hFF, 8'hFF);
      check("R2 unprivileged write ignored", 32'(ctlValue), 32'(expCtl));
    end

    // R1 masked writes
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d, m;
      d = 8'(i * 37 + 5);
      m = 8'(i * 91 + 3);
      ctlWrite('0, d, m);
      expCtl = (expCtl & ~m) | (d & m);
      check("R1 masked write", 32'(ctlValue), 32'(expCtl));
    end
    ctlWrite('0, 8'h00, 8'h01);
    expCtl = expCtl & 8'hFE;
    check("R1 clear enable only", 32'(ctlValue), 32'(expCtl));

    // R6 pass-through sweep over all byte values
    idle(2);
    passCnt = 0;
    for (int b = 0; b < 256; b++) putByte(8'(b), b[0]);
    idle(3);
    check("R6 pass count", 32'(passCnt), 32'd256);
    for (int b = 0; b < 256; b++)
      check("R6 pass byte", 32'(passLog[b]), 32'({b[0], 8'(b)}));

    // R4 disabled entry at each privilege
    idle(2);
    passCnt = 0;
    for (int p = 0; p < 4; p++) begin
      privLevel = PRIV_W'(p);
      putByte(8'h0F, 1'b1);
      putByte(8'h3F, 1'b0);
      check("R4 invalid pulse", 32'(invalidOp), 32'd1);
      check("R4 no branch", 32'(branchValid), 32'd0);
      idle(1);
      check("R4 mode unchanged", 32'(altMode), 32'd0);
    end
    idle(2);
    check("R4 no bytes passed", 32'(passCnt), 32'd0);

    // R5 markers decide recognition
    passCnt = 0;
    putByte(8'h0F, 1'b0);
    putByte(8'h3F, 1'b0);
    check("R5 non-start escape", 32'(invalidOp), 32'd0);
    putByte(8'h0F, 1'b1);
    putByte(8'h3F, 1'b1);
    check("R5 start-marked second byte", 32'(invalidOp), 32'd0);
    putByte(8'h0F, 1'b1);
    putByte(8'h0F, 1'b1);
    putByte(8'h3F, 1'b0);
    check("R5 second escape recognized", 32'(invalidOp), 32'd1);
    idle(3);
    check("R5 pass count", 32'(passCnt), 32'd5);
    check("R5 pass 0", 32'(passLog[0]), 32'h00F);
    check("R5 pass 1", 32'(passLog[1]), 32'h03F);
    check("R5 pass 2", 32'(passLog[2]), 32'h10F);
    check("R5 pass 3", 32'(passLog[3]), 32'h13F);
    check("R5 pass 4", 32'(passLog[4]), 32'h10F);

    // Enable, then an unprivileged attempt to clear
    ctlWrite('0, 8'hFF, 8'h01);
    expCtl = expCtl | 8'h01;
    check("R1 set enable", 32'(ctlValue), 32'(expCtl));
    ctlWrite(2'd2, 8'h00, 8'h01);
    check("R2 enable kept", 32'(ctlValue), 32'(expCtl));

    // R3 R7 R8 R9 across privilege levels and segment sizes
    passCnt = 0;
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 2; c++) begin
        privLevel = PRIV_W'(p);
        cs16 = c[0];
        enterAlt(32'h4000_0000 + 32'(p * 4096 + c * 16 + 7));
        for (int k = 0; k < 3; k++)
          sendWord(32'h0102_0304 * 32'(k + 1) + 32'(p), c[0]);
        sendWord(32'h00A5_A5A5, c[0]);
        sendWord({RET_OPC, 8'(p), 8'(c), 8'h3C}, c[0]);
        idle(1);
        check("R9 back in normal mode", 32'(altMode), 32'd0);
      end
    end
    cs16 = 1'b0;
    idle(2);
    check("R6 nothing passed in alternate mode", 32'(passCnt), 32'd0);

    // R10 wrapper mismatch sweep
    for (int pos = 0; pos < 3; pos++) begin
      for (int bit_i = 0; bit_i < 8; bit_i++) begin
        enterAlt(32'(pos * 8 + bit_i));
        for (int g = 0; g < pos; g++) putByte(good[g], 1'b0);
        putByte(good[pos] ^ 8'(1 << bit_i), 1'b0);
        check("R10 mismatch fault", 32'(invalidOp), 32'd1);
        check("R10 mismatch exits", 32'(altMode), 32'd0);
      end
    end
    cs16 = 1'b1;
    enterAlt(32'h1234_5678);
    putByte(8'h8D, 1'b0);
    check("R10 missing prefix", 32'(invalidOp), 32'd1);
    cs16 = 1'b0;
    enterAlt(32'h1234_5679);
    putByte(8'h67, 1'b0);
    check("R10 unexpected prefix", 32'(invalidOp), 32'd1);
    idle(2);
    passCnt = 0;
    putByte(8'h55, 1'b1);
    idle(2);
    check("R10 pass resumes", 32'(passCnt), 32'd1);
    check("R10 pass byte", 32'(passLog[0]), 32'h155);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule